// File: doc/BRIEF.md
# Longword-to-Word Access Splitter

This block connects a 32-bit master to a 16-bit register space whose bus cycles have a fixed length of `CYC` clocks, at least three. A request of byte, word or longword size comes in on a valid/ready channel. Byte and word requests become one peripheral cycle. A longword request becomes two word cycles that follow each other with no gap. The high half-word goes to the even address first, and the low half-word goes to address+2 second. A lock output covers both halves so that an external arbiter cannot hand the bus to another requester between them. Reads and writes follow the same rules.

For a longword read, the first half-word that comes back is kept in a holding register. The combined 32-bit result is presented only after the second half has been sampled. A misaligned word or longword request, or a request with the reserved size code, produces no peripheral cycle. It gets an error response straight away.

The request channel takes a new request only when the block is idle. The response channel holds `rsp_valid`, the data and the error flag steady until the master accepts them with `rsp_ready`. While a response is waiting, `req_ready` stays low, so back-pressure on the response side stalls the request side.

Top module: `wsplit_bridge`

## Requirements
- R1: A byte or word request that is correctly aligned drives exactly one peripheral cycle. In that cycle `per_sel` is high for exactly `CYC` consecutive clocks at one address.
- R2: A longword request at an address with bits [1:0] = 0 drives two cycles of `CYC` clocks each, with no gap between them, for 2*`CYC` contiguous clocks of `per_sel`. The first cycle uses the request address and the second uses address+2.
- R3: `bus_lock` is high on every clock of both halves of a longword access. It is low on all other clocks, including all byte and word accesses.
- R4: On a longword read, `rsp_rdata` = {data of the first half, data of the second half}. `rsp_valid` rises on the clock right after the last clock of the second half.
- R5: The byte lanes are big-endian. For a byte access the address is the word-aligned address. If address bit 0 = 0, `per_be` = 2'b10 and the read byte comes from `per_rdata`[15:8]; if bit 0 = 1, `per_be` = 2'b01 and it comes from [7:0]. The byte is returned in `rsp_rdata`[7:0] with the upper bits zero. Word and longword accesses use `per_be` = 2'b11, and a word read returns `rsp_rdata` = {16'h0, `per_rdata`}.
- R6: Size codes are 0 = byte, 1 = word, 2 = longword and 3 = reserved. The following requests drive no peripheral cycle and give `rsp_err` = 1 with `rsp_rdata` = 0 on the clock after acceptance:
  - a word request with address bit 0 set;
  - a longword request with address bits [1:0] not zero;
  - any request with size code 3.
- R7: `req_ready` is high only when the block is idle. Once `rsp_valid` is high, it and `rsp_rdata`/`rsp_err` stay unchanged until a clock where `rsp_ready` is high. After that clock the block is idle again.
- R8: `per_write` follows the request direction on every clock of a cycle. The write data is:
  - for a longword, `req_wdata`[31:16] in the first half and [15:0] in the second;
  - for a word, `req_wdata`[15:0];
  - for a byte, `req_wdata`[7:0] copied onto both lanes.
  A write response has `rsp_rdata` = 0.
- R9: Out of reset, `per_sel`, `bus_lock` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for byte and word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read result, right-aligned |
| rsp_err | output | 1 | Misaligned or reserved-size request |
| per_sel | output | 1 | Peripheral cycle active |
| per_write | output | 1 | Peripheral cycle is a write |
| per_addr | output | AW | Word-aligned peripheral address |
| per_be | output | 2 | Lane enables, bit 1 = even byte [15:8] |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, sampled on the last clock of a cycle |
| bus_lock | output | 1 | Arbiter hold across a longword pair |

## Verification
A cycle counter that is wrong shows up at once as a `per_sel` run that is shorter or longer than `CYC` clocks. It also shifts the clock on which `rsp_valid` rises. A half-select flag that is stuck or flips too early shows up within one access as a repeated address, a missing address+2 cycle, or swapped halves in the read result or write data. A holding register or error flag that is stale shows up in the very next response. The sweep covers every size code, every address offset and both directions, so each of these faults reaches a port within one transaction.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  localparam int unsigned LANES = 2;
  localparam int unsigned HW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/wsplit_decode.sv
module wsplit_decode
  import wsplit_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  xfer_size_e       size,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic             err,
  output logic             is_long,
  output logic [LANES-1:0] be,
  output logic [AW-1:0]    base,
  output logic [HW-1:0]    first_data,
  output logic [HW-1:0]    second_data
);
  logic is_byte;

  always_comb begin
    err     = 1'b0;
    is_long = 1'b0;
    is_byte = 1'b0;
    unique case (size)
      SZ_BYTE: is_byte = 1'b1;
      SZ_WORD: err = addr[0];
      SZ_LONG: begin
        is_long = 1'b1;
        err     = |addr[1:0];
      end
      default: err = 1'b1;
    endcase
  end

  assign base = {addr[AW-1:1], 1'b0};

  // Lane 1 carries the even byte (big-endian)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be[l] = is_byte ? (addr[0] == (l == 0)) : 1'b1;
  end

  always_comb begin
    if (is_long) begin
      first_data  = wdata[31:16];
      second_data = wdata[15:0];
    end else if (is_byte) begin
      first_data  = {wdata[7:0], wdata[7:0]};
      second_data = {wdata[7:0], wdata[7:0]};
    end else begin
      first_data  = wdata[15:0];
      second_data = wdata[15:0];
    end
  end
endmodule

// File: rtl/wsplit_timer.sv
module wsplit_timer #(
  parameter int unsigned CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (last)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wsplit_gather.sv
module wsplit_gather
  import wsplit_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_first,
  input  logic          cap_final,
  input  xfer_size_e    size,
  input  logic          bsel,
  input  logic [HW-1:0] rdata,
  output logic [31:0]   result
);
  logic [HW-1:0] hold_q;
  logic [7:0]    lane_byte;

  // bsel = address bit 0; odd byte lives on lane 0
  assign lane_byte = bsel ? rdata[7:0] : rdata[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      result <= '0;
    end else begin
      if (clr) result <= '0;
      if (cap_first) hold_q <= rdata;
      if (cap_final) begin
        unique case (size)
          SZ_LONG: result <= {hold_q, rdata};
          SZ_BYTE: result <= {24'h0, lane_byte};
          default: result <= {16'h0, rdata};
        endcase
      end
    end
  end
endmodule

// File: rtl/wsplit_bridge.sv
module wsplit_bridge
  import wsplit_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          per_sel,
  output logic          per_write,
  output logic [AW-1:0] per_addr,
  output logic [1:0]    per_be,
  output logic [15:0]   per_wdata,
  input  logic [15:0]   per_rdata,
  output logic          bus_lock
);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  bridge_state_e state;
  xfer_size_e    size_in, size_q;
  logic          dec_err, dec_long;
  logic [1:0]    dec_be;
  logic [AW-1:0] dec_base;
  logic [15:0]   dec_d1, dec_d2;

  logic          half_q, long_q, write_q, err_q, bsel_q;
  logic [1:0]    be_q;
  logic [AW-1:0] base_q;
  logic [15:0]   d1_q, d2_q;

  logic accept, cyc_last, in_bus, final_half;

  assign size_in = xfer_size_e'(req_size);

  wsplit_decode #(.AW(AW)) u_dec (
    .size        (size_in),
    .addr        (req_addr),
    .wdata       (req_wdata),
    .err         (dec_err),
    .is_long     (dec_long),
    .be          (dec_be),
    .base        (dec_base),
    .first_data  (dec_d1),
    .second_data (dec_d2)
  );

  assign in_bus     = (state == ST_BUS);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign final_half = !long_q || half_q;

  wsplit_timer #(.CYC(CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_bus),
    .last  (cyc_last)
  );

  wsplit_gather u_gth (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .cap_first (cyc_last && !final_half && !write_q),
    .cap_final (cyc_last && final_half && !write_q),
    .size      (size_q),
    .bsel      (bsel_q),
    .rdata     (per_rdata),
    .result    (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      half_q  <= 1'b0;
      long_q  <= 1'b0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      bsel_q  <= 1'b0;
      be_q    <= '0;
      base_q  <= '0;
      d1_q    <= '0;
      d2_q    <= '0;
      size_q  <= SZ_BYTE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          size_q  <= size_in;
          write_q <= req_write;
          bsel_q  <= req_addr[0];
          be_q    <= dec_be;
          base_q  <= dec_base;
          d1_q    <= dec_d1;
          d2_q    <= dec_d2;
          long_q  <= dec_long && !dec_err;
          half_q  <= 1'b0;
          err_q   <= dec_err;
          state   <= dec_err ? ST_RESP : ST_BUS;
        end
        ST_BUS: if (cyc_last) begin
          if (final_half) state  <= ST_RESP;
          else            half_q <= 1'b1;
        end
        ST_RESP: if (rsp_ready) begin
          state  <= ST_IDLE;
          half_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign per_sel   = in_bus;
  assign per_write = in_bus && write_q;
  assign per_addr  = half_q ? (base_q + HALF_STEP) : base_q;
  assign per_be    = in_bus ? be_q : 2'b00;
  assign per_wdata = half_q ? d2_q : d1_q;
  assign bus_lock  = in_bus && long_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
endmodule

// File: rtl/wsplit_checker.sv
module wsplit_checker #(
  parameter int unsigned AW  = 12,
  parameter int unsigned CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          rsp_err,
  input logic          per_sel,
  input logic [AW-1:0] per_addr,
  input logic          bus_lock
);
  logic [7:0]    run_q;
  logic [AW-1:0] addr_q;
  logic          sel_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      addr_q   <= '0;
      sel_seen <= 1'b0;
    end else begin
      addr_q <= per_addr;
      if (!per_sel)                              run_q <= '0;
      else if (run_q != 0 && per_addr != addr_q) run_q <= 8'd1;
      else if (run_q != 8'hFF)                   run_q <= run_q + 1'b1;
      if (req_valid && req_ready) sel_seen <= 1'b0;
      else if (per_sel)           sel_seen <= 1'b1;
    end
  end

  // R1: a run at one address never ends before CYC clocks
  a_r1_min_cycle_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel && run_q != 0 && per_addr != addr_q) |-> run_q >= CYC);
  a_r1_min_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_sel && run_q != 0) |-> run_q >= CYC);

  // R2: within a locked pair the address only steps by two
  a_r2_half_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && $past(bus_lock) && per_addr != $past(per_addr))
      |-> per_addr == $past(per_addr) + AW'(2));

  // R3: lock never stands without an active cycle
  a_r3_lock_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> per_sel);

  // R6: an error response follows no peripheral cycle
  a_r6_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !sel_seen);

  // R7: held response stays stable
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel || rsp_valid) |-> !req_ready);
endmodule

bind wsplit_bridge wsplit_checker #(.AW(AW), .CYC(CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .per_sel   (per_sel),
  .per_addr  (per_addr),
  .bus_lock  (bus_lock)
);

// File: tb/wsplit_bridge_bench.sv
`timescale 1ns/1ps
module wsplit_bridge_bench;
  localparam int AW  = 12;
  localparam int CYC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [1:0]    req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err, per_sel, per_write, bus_lock;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] per_addr;
  logic [1:0]    per_be;
  logic [15:0]   per_wdata, per_rdata;

  always #2.5 clk = ~clk;

  wsplit_bridge #(.AW(AW), .CYC(CYC)) u_wsplit_bridge (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .per_sel(per_sel), .per_write(per_write),
    .per_addr(per_addr), .per_be(per_be), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .bus_lock(bus_lock)
  );

  function automatic logic [15:0] model(input logic [AW-1:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E37 + 32'h1234;
    return p[15:0] ^ p[31:16];
  endfunction

  assign per_rdata = per_sel ? model(per_addr) : 16'h0BAD;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, n_sel = 0, n_lock = 0, lock_bad = 0;
  logic [AW-1:0] la  [0:31];
  logic [1:0]    lbe [0:31];
  logic [15:0]   lwd [0:31];
  logic          lwe [0:31];
  int            lcy [0:31];

  always @(posedge clk) begin
    if (per_sel && n_sel < 32) begin
      la[n_sel] = per_addr; lbe[n_sel] = per_be; lwd[n_sel] = per_wdata;
      lwe[n_sel] = per_write; lcy[n_sel] = cyc;
      n_sel = n_sel + 1;
    end
    if (bus_lock) n_lock = n_lock + 1;
    if (bus_lock && !per_sel) lock_bad = lock_bad + 1;
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] wd, input int bp);
    bit exp_err; int nh; logic [AW-1:0] base; logic [1:0] ebe;
    logic [15:0] w1, w2; logic [31:0] erd; logic [15:0] m;
    logic [31:0] rd_s; logic err_s; int k, rcyc, stab_bad, busy_bad, bad;
    exp_err = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0);
    nh   = exp_err ? 0 : (sz == 2'd2 ? 2 : 1);
    base = {a[AW-1:1], 1'b0};
    ebe  = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
    w1 = (sz == 2'd2) ? wd[31:16] : (sz == 2'd0 ? {wd[7:0], wd[7:0]} : wd[15:0]);
    w2 = wd[15:0];
    m  = model(base);
    if (exp_err || we)   erd = 32'h0;
    else if (sz == 2'd2) erd = {m, model(base + AW'(2))};
    else if (sz == 2'd1) erd = {16'h0, m};
    else                 erd = {24'h0, a[0] ? m[7:0] : m[15:8]};

    @(negedge clk);
    n_sel = 0; n_lock = 0; lock_bad = 0;
    chk(req_ready == 1'b1, "R7 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; busy_bad = 0;
    while (!rsp_valid && k < 40) begin
      if (req_ready) busy_bad++;
      @(negedge clk); k++;
    end
    rcyc = cyc; rd_s = rsp_rdata; err_s = rsp_err; stab_bad = 0;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_rdata != rd_s || rsp_err != err_s) stab_bad++;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(busy_bad == 0 && stab_bad == 0, "R7 hold while busy/back-pressured",
        32'(busy_bad + stab_bad), 32'd0);
    chk(!rsp_valid && req_ready, "R7 release after accept", {30'd0, rsp_valid, req_ready}, 32'd1);
    chk(err_s == exp_err, "R6 error flag", 32'(err_s), 32'(exp_err));
    chk(n_sel == nh * CYC, "R1/R2/R6 cycle clocks", 32'(n_sel), 32'(nh * CYC));
    if (nh > 0 && n_sel == nh * CYC) begin
      chk(lcy[n_sel-1] - lcy[0] == n_sel - 1, "R2 contiguous", 32'(lcy[n_sel-1] - lcy[0]), 32'(n_sel - 1));
      chk(rcyc == lcy[n_sel-1] + 1, "R4 response timing", 32'(rcyc), 32'(lcy[n_sel-1] + 1));
      bad = 0;
      for (int i = 0; i < n_sel; i++) begin
        if (la[i] != ((i < CYC) ? base : base + AW'(2))) bad++;
        if (lbe[i] != ebe) bad++;
        if (lwe[i] != we) bad++;
        if (we && lwd[i] != ((i < CYC) ? w1 : w2)) bad++;
      end
      chk(bad == 0, "R2/R5/R8 address, lanes, write data", 32'(bad), 32'd0);
    end
    chk(n_lock == ((nh == 2) ? 2 * CYC : 0) && lock_bad == 0, "R3 lock span",
        32'(n_lock), 32'((nh == 2) ? 2 * CYC : 0));
    chk(rd_s == erd, we ? "R8 write response data" : "R4/R5 read data", rd_s, erd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] bases [0:2];
    bases[0] = 12'h000; bases[1] = 12'h7F8; bases[2] = 12'hFF8;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!per_sel && !bus_lock && !rsp_valid && req_ready, "R9 reset outputs",
        {28'd0, per_sel, bus_lock, rsp_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    for (int b = 0; b < 3; b++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int we = 0; we < 2; we++)
            xfer(we[0], sz[1:0], bases[b] + AW'(off),
                 32'hC0DE_0000 ^ (32'(b * 97 + sz * 13 + off) * 32'h0101_0203), (off + sz) % 4);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule